// File: doc/BRIEF.md
# Margin-Verified Programming Sequencer

This block is the host-side controller that walks one memory location through a programming algorithm with margin checks. After a start request it latches the target address, the write data and whether the location is a user word or a configuration word. It first asks for a blank check at the lowest supply. It then switches to the programming supply and applies fixed-width programming pulses, with a verify request after each pulse, until the location matches or the pulse budget runs out. For user words it then applies extra margin pulses, three for every pulse that was needed. Last, it verifies the location at the minimum supply and then at the maximum supply.

The memory strobing and the analog supplies sit outside this block. The block selects a supply corner through `supply_o` and marks each programming pulse with `pulse_o`. Each compare is requested with a level handshake (`verify_req_o` / `verify_ack_i`), and the compare result comes back on `verify_match_i`. At the end the block raises `done_o` for one cycle and leaves a 2-bit result code on `err_o`.

Top module: `margin_prog_seq`

## Requirements
- R1: A start request is taken only while `busy_o` is low. It latches `addr_i`, `data_i` and `cfg_loc_i` (`addr_o` and `wdata_o` show the latched values), clears `err_o` to 0 and raises `busy_o` on the next cycle. A start request while busy has no effect.
- R2: The first compare of every run is a blank check, with `blank_chk_o` high and `supply_o` = 1 (minimum). If it does not match, the run ends with `err_o` = 1 and no programming pulse.
- R3: Every programming pulse is high for exactly PULSE_CYC cycles with `supply_o` = 0 (programming supply). During the programming phase, one compare at `supply_o` = 0 follows each pulse.
- R4: A user location (`cfg_loc_i` = 0) gets up to USER_LIMIT+1 pulses (26 by default). The run gives up only when a compare fails after more than USER_LIMIT pulses, and then ends with `err_o` = 2.
- R5: After a user location matches following N pulses, exactly 3·N more pulses are applied with no compare between them.
- R6: A configuration location (`cfg_loc_i` = 1) gets up to CFG_LIMIT pulses (100 by default). On failure it ends with `err_o` = 2. On success no margin pulses are applied.
- R7: After programming, one compare is made at `supply_o` = 1 (minimum), and only if it matches, one more at `supply_o` = 2 (maximum). A mismatch at either corner ends the run with `err_o` = 3. A match at both ends it with `err_o` = 0.
- R8: `done_o` is high for exactly one cycle at the end of each run, and `busy_o` falls on the next cycle. `err_o` keeps its value until the next accepted start.
- R9: `verify_req_o` stays high until a cycle with `verify_ack_i` high, and the match result is taken in that cycle. `verify_req_o` and `pulse_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one location |
| cfg_loc_i | input | 1 | 1 = configuration location, 0 = user location |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Data to program |
| addr_o | output | ADDR_W | Latched target address |
| wdata_o | output | DATA_W | Latched data, also the compare pattern |
| supply_o | output | 2 | Supply select: 0 programming, 1 minimum, 2 maximum |
| pulse_o | output | 1 | Programming pulse enable |
| verify_req_o | output | 1 | Compare request |
| blank_chk_o | output | 1 | Current compare is against the erased pattern |
| verify_ack_i | input | 1 | Compare result valid |
| verify_match_i | input | 1 | Compare matched |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| err_o | output | 2 | 0 none, 1 blank fail, 2 unable to program, 3 corner fail |

## Verification
The bench sets PULSE_CYC to 3 so that a pulse is short. It keeps USER_LIMIT at 25 and CFG_LIMIT at 100, so the exact budgets of 26 and 100 pulses, and one pulse beyond each, are exercised at their real values. With these values even a full margin train of 78 pulses after 26 programming pulses finishes in a few hundred cycles. The pulse-width monitor therefore sees every pulse edge in every case.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [1:0] {
    SUP_NOM = 2'd0,
    SUP_MIN = 2'd1,
    SUP_MAX = 2'd2
  } supply_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_BLANK  = 2'd1,
    ERR_NOPROG = 2'd2,
    ERR_CORNER = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BLANK, ST_FIRE, ST_PULSE, ST_PVER,
    ST_MFIRE, ST_MPULSE, ST_CMIN, ST_CMAX, ST_FIN
  } st_e;
endpackage

// File: rtl/mps_pulse_timer.sv
module mps_pulse_timer #(
  parameter int PULSE_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o,
  output logic last_o
);
  localparam int TW = $clog2(PULSE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(PULSE_CYC - 1);

  logic          active_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = active_q;
  assign last_o  = active_q && (cnt_q == LAST);

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !last_o) |=> pulse_o);
endmodule

// File: rtl/mps_pulse_tally.sv
module mps_pulse_tally #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          load_margin_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          margin_last_o
);
  localparam int MW = CW + 2;

  logic [CW-1:0] cnt_q;
  logic [MW-1:0] margin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      margin_q <= '0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      margin_q <= '0;
    end else begin
      if (inc_i) cnt_q <= cnt_q + 1'b1;
      if (load_margin_i)
        margin_q <= (MW'(cnt_q) << 1) + MW'(cnt_q);
      else if (dec_i && margin_q != '0)
        margin_q <= margin_q - 1'b1;
    end
  end

  assign count_o       = cnt_q;
  assign margin_last_o = (margin_q == MW'(1));

  // R5
  margin_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i && !load_margin_i && margin_q != '0) |=> (margin_q == $past(margin_q) - 1'b1));
endmodule

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
#(
  parameter int CW         = 7,
  parameter int USER_LIMIT = 25,
  parameter int CFG_LIMIT  = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_i,
  input  logic          last_i,
  input  logic [CW-1:0] count_i,
  input  logic          margin_last_i,
  input  logic          ack_i,
  input  logic          match_i,
  output logic          take_o,
  output logic          clr_o,
  output logic          fire_o,
  output logic          inc_o,
  output logic          load_margin_o,
  output logic          dec_o,
  output supply_e       supply_o,
  output logic          req_o,
  output logic          blank_o,
  output logic          busy_o,
  output logic          done_o,
  output err_e          err_o
);
  localparam logic [CW-1:0] USER_MAX = CW'(USER_LIMIT + 1);
  localparam logic [CW-1:0] CFG_MAX  = CW'(CFG_LIMIT);

  st_e  state_q, state_d;
  err_e err_q, err_d;
  logic cfg_q;
  logic at_budget;

  assign at_budget = cfg_q ? (count_i >= CFG_MAX) : (count_i >= USER_MAX);

  always_comb begin
    state_d       = state_q;
    err_d         = err_q;
    take_o        = 1'b0;
    clr_o         = 1'b0;
    fire_o        = 1'b0;
    inc_o         = 1'b0;
    load_margin_o = 1'b0;
    dec_o         = 1'b0;
    req_o         = 1'b0;
    blank_o       = 1'b0;
    supply_o      = SUP_NOM;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        take_o  = 1'b1;
        clr_o   = 1'b1;
        err_d   = ERR_NONE;
        state_d = ST_BLANK;
      end
      ST_BLANK: begin
        req_o    = 1'b1;
        blank_o  = 1'b1;
        supply_o = SUP_MIN;
        if (ack_i) begin
          if (match_i) state_d = ST_FIRE;
          else begin
            err_d   = ERR_BLANK;
            state_d = ST_FIN;
          end
        end
      end
      ST_FIRE: begin
        fire_o  = 1'b1;
        state_d = ST_PULSE;
      end
      ST_PULSE: if (last_i) begin
        inc_o   = 1'b1;
        state_d = ST_PVER;
      end
      ST_PVER: begin
        req_o = 1'b1;
        if (ack_i) begin
          if (match_i) begin
            if (cfg_q) state_d = ST_CMIN;
            else begin
              load_margin_o = 1'b1;
              state_d       = ST_MFIRE;
            end
          end else if (at_budget) begin
            err_d   = ERR_NOPROG;
            state_d = ST_FIN;
          end else begin
            state_d = ST_FIRE;
          end
        end
      end
      ST_MFIRE: begin
        fire_o  = 1'b1;
        state_d = ST_MPULSE;
      end
      ST_MPULSE: if (last_i) begin
        dec_o   = 1'b1;
        state_d = margin_last_i ? ST_CMIN : ST_MFIRE;
      end
      ST_CMIN: begin
        req_o    = 1'b1;
        supply_o = SUP_MIN;
        if (ack_i) begin
          if (match_i) state_d = ST_CMAX;
          else begin
            err_d   = ERR_CORNER;
            state_d = ST_FIN;
          end
        end
      end
      ST_CMAX: begin
        req_o    = 1'b1;
        supply_o = SUP_MAX;
        if (ack_i) begin
          if (!match_i) err_d = ERR_CORNER;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      cfg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (take_o) cfg_q <= cfg_i;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign err_o  = err_q;

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(err_o));
  // R2
  blank_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (blank_o && supply_o == SUP_MIN));
endmodule

// File: rtl/margin_prog_seq.sv
module margin_prog_seq
  import mps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 20000,
  parameter int USER_LIMIT = 25,
  parameter int CFG_LIMIT  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_loc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        supply_o,
  output logic              pulse_o,
  output logic              verify_req_o,
  output logic              blank_chk_o,
  input  logic              verify_ack_i,
  input  logic              verify_match_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  localparam int MAXP = (USER_LIMIT + 1 > CFG_LIMIT) ? USER_LIMIT + 1 : CFG_LIMIT;
  localparam int CW   = $clog2(MAXP + 2);

  logic          take, clr, fire, inc, load_m, dec, last, m_last;
  logic [CW-1:0] count;
  supply_e       sup;
  err_e          err;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  mps_ctrl #(.CW(CW), .USER_LIMIT(USER_LIMIT), .CFG_LIMIT(CFG_LIMIT)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cfg_i(cfg_loc_i), .last_i(last),
    .count_i(count), .margin_last_i(m_last), .ack_i(verify_ack_i),
    .match_i(verify_match_i), .take_o(take), .clr_o(clr), .fire_o(fire),
    .inc_o(inc), .load_margin_o(load_m), .dec_o(dec), .supply_o(sup),
    .req_o(verify_req_o), .blank_o(blank_chk_o), .busy_o, .done_o, .err_o(err)
  );

  mps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i, .rst_ni, .fire_i(fire), .pulse_o, .last_o(last)
  );

  mps_pulse_tally #(.CW(CW)) u_tally (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .load_margin_i(load_m),
    .dec_i(dec), .count_o(count), .margin_last_o(m_last)
  );

  assign addr_o   = addr_q;
  assign wdata_o  = data_q;
  assign supply_o = sup;
  assign err_o    = err;

  // R3
  pulse_nom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (supply_o == SUP_NOM));
  // R9
  pulse_req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_o && verify_req_o));
  // R4
  budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(MAXP));
  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o));
endmodule

// File: tb/tb_margin_prog_seq.sv
`timescale 1ns/1ps
module tb_margin_prog_seq;
  localparam int PC = 3;
  localparam int NV = 11;
  // {cfg, need[7:0], blank_ok, cmin_ok, cmax_ok, err[1:0], pulses[8:0]}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'd1,   3'b111, 2'd0, 9'd4},
    {1'b0, 8'd5,   3'b111, 2'd0, 9'd20},
    {1'b0, 8'd26,  3'b111, 2'd0, 9'd104},
    {1'b0, 8'd27,  3'b111, 2'd2, 9'd26},
    {1'b1, 8'd1,   3'b111, 2'd0, 9'd1},
    {1'b1, 8'd100, 3'b111, 2'd0, 9'd100},
    {1'b1, 8'd101, 3'b111, 2'd2, 9'd100},
    {1'b0, 8'd1,   3'b011, 2'd1, 9'd0},
    {1'b0, 8'd3,   3'b101, 2'd3, 9'd12},
    {1'b0, 8'd2,   3'b110, 2'd3, 9'd8},
    {1'b1, 8'd4,   3'b110, 2'd3, 9'd4}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, cfg_loc_i = 1'b0;
  logic [15:0] addr_i = '0, data_i = '0, addr_o, wdata_o;
  logic [1:0] supply_o, err_o;
  logic pulse_o, verify_req_o, blank_chk_o, busy_o, done_o;
  logic verify_ack_i = 1'b0, verify_match_i = 1'b0;

  always #2.5 clk = ~clk;

  margin_prog_seq #(.PULSE_CYC(PC)) dut (
    .clk_i(clk), .rst_ni, .start_i, .cfg_loc_i, .addr_i, .data_i, .addr_o,
    .wdata_o, .supply_o, .pulse_o, .verify_req_o, .blank_chk_o, .verify_ack_i,
    .verify_match_i, .busy_o, .done_o, .err_o
  );

  int n_run = 0, n_fail = 0;
  int m_need = 0;
  bit m_blank = 1, m_cmin = 1, m_cmax = 1;
  int pulses = 0, nom_ver = 0, max_ver = 0, bad_sup = 0, bad_w = 0, hi_len = 0;
  bit pulse_prev = 0;

  // memory model and monitors, all on the falling edge
  always @(negedge clk) begin
    if (pulse_o) begin
      if (!pulse_prev) pulses++;
      if (supply_o != 2'd0) bad_sup++;
      hi_len++;
    end else if (hi_len != 0) begin
      if (hi_len != PC) bad_w++;
      hi_len = 0;
    end
    pulse_prev = pulse_o;
    if (verify_req_o && !verify_ack_i) begin
      verify_ack_i = 1'b1;
      if (blank_chk_o) begin
        if (supply_o != 2'd1) bad_sup++;
        verify_match_i = m_blank;
      end else if (supply_o == 2'd0) begin
        nom_ver++;
        verify_match_i = (pulses >= m_need);
      end else if (supply_o == 2'd1) verify_match_i = m_cmin;
      else begin
        max_ver++;
        verify_match_i = m_cmax;
      end
    end else begin
      verify_ack_i = 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(bit cfg, int need, bit b, bit cmn, bit cmx, logic [15:0] a, logic [15:0] d);
    m_need = need; m_blank = b; m_cmin = cmn; m_cmax = cmx;
    pulses = 0; nom_ver = 0; max_ver = 0; bad_sup = 0; bad_w = 0;
    @(negedge clk);
    cfg_loc_i = cfg; addr_i = a; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int wd = 0;
    ok = 1;
    while (!done_o) begin
      @(negedge clk);
      wd++;
      if (wd > 5000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
        ok = 0;
        return;
      end
    end
    @(negedge clk);
    chk("R8 done one cycle", int'(done_o), 0);
    chk("R8 busy after done", int'(busy_o), 0);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R8 reset err", int'(err_o), 0);
    chk("R9 reset req", int'(verify_req_o), 0);
    chk("R3 reset pulse", int'(pulse_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      int maxp, expn, expmx;
      string tag;
      v = VEC[i];
      launch(v[22], int'(v[21:14]), v[13], v[12], v[11], 16'(16'h1000 + i), 16'(16'hA500 + i));
      chk("R1 busy after start", int'(busy_o), 1);
      chk("R1 err cleared", int'(err_o), 0);
      wait_done(ok);
      if (!ok) break;
      case (i)
        2, 3:    tag = "R4";
        4, 5, 6: tag = "R6";
        7:       tag = "R2";
        8, 9, 10: tag = "R7";
        default: tag = "R5";
      endcase
      maxp  = v[22] ? 100 : 26;
      expn  = !v[13] ? 0 : (int'(v[21:14]) <= maxp ? int'(v[21:14]) : maxp);
      expmx = (v[10:9] == 2'd0 || (v[10:9] == 2'd3 && v[12])) ? 1 : 0;
      chk({tag, " err code"}, int'(err_o), int'(v[10:9]));
      chk({tag, " pulse count"}, pulses, int'(v[8:0]));
      chk("R3 verify per pulse", nom_ver, expn);
      chk("R7 max corner order", max_ver, expmx);
      chk("R3 pulse width/supply", bad_w + bad_sup, 0);
      chk("R1 address latched", int'(addr_o), 16'h1000 + i);
      chk("R1 data latched", int'(wdata_o), 16'hA500 + i);
    end

    // R8: err held while idle, cleared by next start
    launch(1'b0, 30, 1'b1, 1'b1, 1'b1, 16'h0BAD, 16'h0001);
    wait_done(ok);
    repeat (10) @(negedge clk);
    chk("R8 err held", int'(err_o), 2);
    // R1: start while busy is ignored
    launch(1'b0, 2, 1'b1, 1'b1, 1'b1, 16'h2222, 16'h3333);
    chk("R1 err cleared on start", int'(err_o), 0);
    repeat (4) @(negedge clk);
    cfg_loc_i = 1'b1; addr_i = 16'h7777; data_i = 16'h8888; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    chk("R1 busy start ignored addr", int'(addr_o), 16'h2222);
    chk("R1 busy start ignored data", int'(wdata_o), 16'h3333);
    chk("R1 busy start ignored kind", pulses, 8);
    chk("R1 busy start ignored err", int'(err_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule